// File: doc/BRIEF.md
# I2C Event and Clock-Stretch Controller

This block sits beside the bit engine of an I2C controller. It decides on which SCL falling edge of a byte the controller raises its event interrupt, and whether it then holds SCL low so that software can service the byte. It works in both the master and the slave role. It synchronizes SCL into the system clock domain and counts the falling edges of each byte. It also tracks whether the current byte is the first (address) byte after a START or a repeated START, or a data byte.

For data bytes, one select input places the event either after the eighth clock (data bits only) or after the ninth clock (after the acknowledge). The address byte follows fixed rules. A master always stops after the ninth clock. A slave whose own address matched stops after the ninth clock and acknowledges even when software has disabled acknowledgement. A slave that saw an extension code stops after the eighth clock. A slave that is not addressed stays silent, except after a repeated START, where it reports the mismatch with an interrupt but no stretch.

A stretch lasts until software pulses the release input. The bit engine supplies START/STOP detection and the address-match and extension-code flags. This block only times the events.

Top module: `i2c_evt_ctrl`

## Requirements
- R1: Falling edges of SCL are counted 1 to 9 within a byte. The count restarts on START or repeated START, and a falling edge is counted only after a rising edge has been seen since that START. The 9th edge ends the byte. The first byte after any START is the address byte.
- R2: In the master role the address byte gives its interrupt and stretch on edge 9, whatever the value of `wait_on_ninth`.
- R3: For a data byte, in the master role or for a selected slave, the interrupt and stretch come on edge 8 when `wait_on_ninth` is 0 and on edge 9 when it is 1.
- R4: A slave whose `addr_match` is high at edge 8 of the address byte gives its interrupt and stretch on edge 9, whatever the value of `wait_on_ninth`.
- R5: Between edges 8 and 9 of a slave address byte, `ack_drive` equals `addr_match`, even when `ack_en` is 0. In data bytes, `ack_drive` equals `ack_en` in the master role or for a selected slave, and is 0 otherwise.
- R6: A slave with `ext_code` high at edge 8 of the address byte gives its interrupt and stretch on edge 8. The extension code takes precedence over a match, and there is no further event on edge 9.
- R7: After a repeated START, a slave with neither match nor extension code gives an interrupt on edge 9 with `scl_hold` low, and no events in the data bytes that follow.
- R8: A slave with neither match nor extension code after a first START (no repeated START since the last STOP) gives no interrupt and no stretch, for the address byte and for all data bytes.
- R9: `scl_hold` rises in the same cycle as the interrupt pulse of a stretching event. It stays high until `sw_release` is pulsed, and falls on the next clock edge after that pulse.
- R10: `irq` is a single-cycle pulse, with exactly one pulse per qualifying edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line level, asynchronous |
| start_det | input | 1 | One-cycle pulse on START or repeated START |
| stop_det | input | 1 | One-cycle pulse on STOP |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| wait_on_ninth | input | 1 | Data-byte event point: 0 = edge 8, 1 = edge 9 |
| ack_en | input | 1 | Software acknowledge enable |
| addr_match | input | 1 | Received address equals own address (valid from edge 8) |
| ext_code | input | 1 | Received address is an extension code (valid from edge 8) |
| sw_release | input | 1 | One-cycle pulse that ends a stretch |
| irq | output | 1 | Event interrupt pulse |
| scl_hold | output | 1 | Hold SCL low |
| ack_drive | output | 1 | Drive acknowledge on the 9th clock |

## Verification
The bench builds the block with eight data bits and a two-stage synchronizer. Each byte therefore has nine counted edges, and the edge-8 and edge-9 event points are distinct observable moments. With a half SCL period of twelve system clocks, every synchronized edge and registered decision settles well inside one SCL phase. This allows each interrupt to be tied to the exact edge the bench has just driven. Stretches are resolved through the line model, in which the bench's SCL is ANDed with `scl_hold`. This exercises master, matched-slave, extension-code, repeated-START mismatch and unaddressed sequences with both settings of the select bit.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;

  // Slave selection state resolved at edge 8 of the address byte
  typedef enum logic [1:0] {
    SL_NONE  = 2'd0,
    SL_MATCH = 2'd1,
    SL_EXT   = 2'd2
  } slv_sel_t;

  // Width of an edge index able to hold DATA_BITS+1
  function automatic int edge_w(input int data_bits);
    return $clog2(data_bits + 2);
  endfunction

endpackage

// File: rtl/i2c_evt_scl_edge.sv
module i2c_evt_scl_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_async,
  output logic scl_fall,
  output logic scl_rise
);
  localparam int TAP = SYNC_STAGES;

  // sh[0..TAP-1] synchronizer chain, sh[TAP] one-cycle delayed copy
  logic [TAP:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '1;
    end else begin
      sh <= {sh[TAP-1:0], scl_async};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_fall <= 1'b0;
      scl_rise <= 1'b0;
    end else begin
      scl_fall <= sh[TAP] & ~sh[TAP-1];
      scl_rise <= ~sh[TAP] & sh[TAP-1];
    end
  end

  assert_edges_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
    !(scl_fall && scl_rise));

endmodule

// File: rtl/i2c_evt_bitcnt.sv
module i2c_evt_bitcnt #(
  parameter int DATA_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_fall,
  input  logic scl_rise,
  input  logic start_det,
  input  logic stop_det,
  output logic edge_vld,
  output logic [i2c_evt_pkg::edge_w(DATA_BITS)-1:0] edge_num,
  output logic edge_addr,
  output logic addr_phase
);
  localparam int CW = i2c_evt_pkg::edge_w(DATA_BITS);
  localparam logic [CW-1:0] LAST_C = CW'(DATA_BITS + 1);

  logic          armed;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;

  always_comb cnt_nxt = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed      <= 1'b0;
      cnt        <= '0;
      addr_phase <= 1'b0;
      edge_vld   <= 1'b0;
      edge_num   <= '0;
      edge_addr  <= 1'b0;
    end else begin
      edge_vld <= 1'b0;
      if (start_det) begin
        armed      <= 1'b0;
        cnt        <= '0;
        addr_phase <= 1'b1;
      end else if (stop_det) begin
        armed      <= 1'b0;
        cnt        <= '0;
        addr_phase <= 1'b0;
      end else begin
        if (scl_rise) armed <= 1'b1;
        if (scl_fall && armed) begin
          edge_vld  <= 1'b1;
          edge_num  <= cnt_nxt;
          edge_addr <= addr_phase;
          if (cnt_nxt == LAST_C) begin
            cnt        <= '0;
            addr_phase <= 1'b0;
          end else begin
            cnt <= cnt_nxt;
          end
        end
      end
    end
  end

  assert_edge_window_R1: assert property (@(posedge clk) disable iff (rst)
    edge_vld |-> (edge_num != '0) && (edge_num <= LAST_C));

  assert_start_clears_R1: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !edge_vld && addr_phase);

endmodule

// File: rtl/i2c_evt_policy.sv
module i2c_evt_policy #(
  parameter int DATA_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_det,
  input  logic stop_det,
  input  logic edge_vld,
  input  logic [i2c_evt_pkg::edge_w(DATA_BITS)-1:0] edge_num,
  input  logic edge_addr,
  input  logic addr_phase,
  input  logic is_master,
  input  logic wait_on_ninth,
  input  logic ack_en,
  input  logic addr_match,
  input  logic ext_code,
  input  logic sw_release,
  output logic irq,
  output logic scl_hold,
  output logic ack_drive
);
  import i2c_evt_pkg::*;

  localparam int CW = edge_w(DATA_BITS);
  localparam logic [CW-1:0] LAST_C = CW'(DATA_BITS + 1);
  localparam logic [CW-1:0] BYTE_C = CW'(DATA_BITS);

  logic     busy, restart;
  slv_sel_t sel, sel_nxt;
  logic     fire, stall;
  logic [CW-1:0] data_pt;

  always_comb data_pt = wait_on_ninth ? LAST_C : BYTE_C;

  always_comb begin
    fire    = 1'b0;
    stall   = 1'b0;
    sel_nxt = sel;
    if (edge_vld) begin
      if (is_master) begin
        fire  = edge_addr ? (edge_num == LAST_C) : (edge_num == data_pt);
        stall = fire;
      end else if (edge_addr) begin
        if (edge_num == BYTE_C) begin
          if (ext_code) begin
            sel_nxt = SL_EXT;
            fire    = 1'b1;
            stall   = 1'b1;
          end else if (addr_match) begin
            sel_nxt = SL_MATCH;
          end else begin
            sel_nxt = SL_NONE;
          end
        end else if (edge_num == LAST_C) begin
          if (sel == SL_MATCH) begin
            fire  = 1'b1;
            stall = 1'b1;
          end else if (sel == SL_NONE && restart) begin
            fire = 1'b1;
          end
        end
      end else if (sel != SL_NONE && edge_num == data_pt) begin
        fire  = 1'b1;
        stall = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      restart <= 1'b0;
      sel     <= SL_NONE;
    end else if (start_det) begin
      restart <= busy;
      busy    <= 1'b1;
      sel     <= SL_NONE;
    end else if (stop_det) begin
      busy    <= 1'b0;
      restart <= 1'b0;
      sel     <= SL_NONE;
    end else begin
      sel <= sel_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      scl_hold  <= 1'b0;
      ack_drive <= 1'b0;
    end else begin
      irq <= fire;
      if (fire && stall)   scl_hold <= 1'b1;
      else if (sw_release) scl_hold <= 1'b0;
      if (is_master)       ack_drive <= !addr_phase && ack_en;
      else if (addr_phase) ack_drive <= addr_match;
      else                 ack_drive <= ack_en && (sel != SL_NONE);
    end
  end

  assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  assert_hold_with_irq_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_hold) |-> irq);

  assert_hold_until_release_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_hold) |-> $past(sw_release));

  assert_master_addr_ninth_R2: assert property (@(posedge clk) disable iff (rst)
    (irq && $past(edge_vld && edge_addr && is_master)) |-> ($past(edge_num) == LAST_C));

  assert_ext_stretch_R6: assert property (@(posedge clk) disable iff (rst)
    $past(edge_vld && edge_addr && !is_master && ext_code && edge_num == BYTE_C)
      |-> (irq && scl_hold));

  assert_nowait_only_restart_R7: assert property (@(posedge clk) disable iff (rst)
    (irq && !scl_hold) |-> $past(restart && !is_master && edge_addr));

endmodule

// File: rtl/i2c_evt_ctrl.sv
module i2c_evt_ctrl #(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic start_det,
  input  logic stop_det,
  input  logic is_master,
  input  logic wait_on_ninth,
  input  logic ack_en,
  input  logic addr_match,
  input  logic ext_code,
  input  logic sw_release,
  output logic irq,
  output logic scl_hold,
  output logic ack_drive
);
  localparam int CW = i2c_evt_pkg::edge_w(DATA_BITS);

  logic          fall, rise;
  logic          edge_vld, edge_addr, addr_phase;
  logic [CW-1:0] edge_num;

  i2c_evt_scl_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .scl_async(scl_in),
    .scl_fall(fall), .scl_rise(rise)
  );

  i2c_evt_bitcnt #(.DATA_BITS(DATA_BITS)) u_cnt (
    .clk(clk), .rst(rst), .scl_fall(fall), .scl_rise(rise),
    .start_det(start_det), .stop_det(stop_det),
    .edge_vld(edge_vld), .edge_num(edge_num),
    .edge_addr(edge_addr), .addr_phase(addr_phase)
  );

  i2c_evt_policy #(.DATA_BITS(DATA_BITS)) u_pol (
    .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
    .edge_vld(edge_vld), .edge_num(edge_num), .edge_addr(edge_addr),
    .addr_phase(addr_phase), .is_master(is_master),
    .wait_on_ninth(wait_on_ninth), .ack_en(ack_en),
    .addr_match(addr_match), .ext_code(ext_code), .sw_release(sw_release),
    .irq(irq), .scl_hold(scl_hold), .ack_drive(ack_drive)
  );

endmodule

// File: tb/i2c_evt_ctrl_test.sv
module i2c_evt_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic drv_scl = 1'b1;
  logic start_det = 1'b0, stop_det = 1'b0;
  logic is_master = 1'b0, wait_on_ninth = 1'b0, ack_en = 1'b0;
  logic addr_match = 1'b0, ext_code = 1'b0, sw_release = 1'b0;
  logic irq, scl_hold, ack_drive;
  logic scl_line;

  int checks = 0;
  int errors = 0;
  int cur_edge = 0;
  bit last_irq = 1'b0;

  typedef struct {
    int    edge_no;
    bit    hold;
    string req;
  } exp_t;
  exp_t q[$];
  exp_t e;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_line = drv_scl & ~scl_hold;

  i2c_evt_ctrl uut (
    .clk(clk), .rst(rst), .scl_in(scl_line),
    .start_det(start_det), .stop_det(stop_det),
    .is_master(is_master), .wait_on_ninth(wait_on_ninth),
    .ack_en(ack_en), .addr_match(addr_match), .ext_code(ext_code),
    .sw_release(sw_release),
    .irq(irq), .scl_hold(scl_hold), .ack_drive(ack_drive)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int edge_no, input bit hold, input string req);
    exp_t x;
    x.edge_no = edge_no;
    x.hold    = hold;
    x.req     = req;
    q.push_back(x);
  endtask

  // monitor: pops one expected item per interrupt pulse
  always @(negedge clk) begin
    if (!rst) begin
      if (last_irq) chk(!irq, "R10", "irq longer than one cycle", irq, 0);
      if (irq) begin
        if (q.size() == 0) begin
          chk(1'b0, "R8", "unexpected interrupt at edge", cur_edge, 0);
        end else begin
          e = q.pop_front();
          chk(cur_edge == e.edge_no, e.req, "interrupt edge (R1)", cur_edge, e.edge_no);
          chk(scl_hold == e.hold, e.req, "stretch at interrupt", scl_hold, e.hold);
        end
      end
      last_irq <= irq;
    end
  end

  task automatic do_start();
    drv_scl = 1'b1; wt(HALF);
    start_det = 1'b1; wt(1); start_det = 1'b0;
    wt(HALF);
    drv_scl = 1'b0; wt(HALF);
  endtask

  task automatic do_stop();
    drv_scl = 1'b1; wt(HALF);
    stop_det = 1'b1; wt(1); stop_det = 1'b0;
    wt(HALF);
  endtask

  task automatic send_byte(input bit ack_chk, input bit exp_ack, input string req);
    for (int k = 1; k <= 9; k++) begin
      drv_scl = 1'b1; wt(HALF);
      drv_scl = 1'b0; cur_edge = k; wt(HALF);
      if (k == 8 && ack_chk) chk(ack_drive == exp_ack, req, "ack_drive", ack_drive, exp_ack);
      if (scl_hold) begin
        wt(3);
        chk(scl_hold == 1'b1, "R9", "stretch held before release", scl_hold, 1);
        sw_release = 1'b1; wt(1); sw_release = 1'b0;
        wt(1);
        chk(scl_hold == 1'b0, "R9", "stretch after release", scl_hold, 0);
      end
    end
  endtask

  task automatic drained(input string req);
    wt(6);
    chk(q.size() == 0, req, "expected events left", q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wt(5);
    rst = 1'b0;
    wt(2);
    chk(irq == 1'b0, "R10", "irq after reset", irq, 0);
    chk(scl_hold == 1'b0, "R9", "scl_hold after reset", scl_hold, 0);
    chk(ack_drive == 1'b0, "R5", "ack_drive after reset", ack_drive, 0);

    // master, select 0 then 1 within one transfer
    is_master = 1'b1; wait_on_ninth = 1'b0; ack_en = 1'b1;
    do_start();
    push(9, 1, "R2"); send_byte(1'b0, 1'b0, "R2");
    push(8, 1, "R3"); send_byte(1'b1, 1'b1, "R5");
    wait_on_ninth = 1'b1;
    push(9, 1, "R3"); send_byte(1'b0, 1'b0, "R3");
    do_stop(); drained("R3");

    // master address with select 1
    do_start();
    push(9, 1, "R2"); send_byte(1'b0, 1'b0, "R2");
    do_stop(); drained("R2");

    // slave, own address matched, ack disabled, select 0
    is_master = 1'b0; wait_on_ninth = 1'b0; ack_en = 1'b0; addr_match = 1'b1;
    do_start();
    push(9, 1, "R4"); send_byte(1'b1, 1'b1, "R5");
    push(8, 1, "R3"); send_byte(1'b1, 1'b0, "R5");
    do_stop(); drained("R4");

    // slave matched, select 1, ack enabled
    wait_on_ninth = 1'b1; ack_en = 1'b1;
    do_start();
    push(9, 1, "R4"); send_byte(1'b0, 1'b0, "R4");
    push(9, 1, "R3"); send_byte(1'b1, 1'b1, "R5");
    do_stop(); drained("R4");

    // slave, extension code takes precedence over match
    ext_code = 1'b1; addr_match = 1'b1; wait_on_ninth = 1'b0;
    do_start();
    push(8, 1, "R6"); send_byte(1'b0, 1'b0, "R6");
    ext_code = 1'b0;
    push(8, 1, "R3"); send_byte(1'b0, 1'b0, "R3");
    do_stop(); drained("R6");

    // slave not addressed: silent for address and data
    addr_match = 1'b0; ack_en = 1'b1;
    do_start();
    send_byte(1'b1, 1'b0, "R8");
    send_byte(1'b1, 1'b0, "R8");
    send_byte(1'b0, 1'b0, "R8");
    do_stop(); drained("R8");

    // slave matched, then repeated START with mismatch
    addr_match = 1'b1; wait_on_ninth = 1'b1;
    do_start();
    push(9, 1, "R4"); send_byte(1'b0, 1'b0, "R4");
    addr_match = 1'b0;
    do_start();
    push(9, 0, "R7"); send_byte(1'b0, 1'b0, "R7");
    send_byte(1'b0, 1'b0, "R7");
    drained("R7");
    do_stop();

    // after STOP the restart flag is gone: mismatch stays silent
    do_start();
    send_byte(1'b0, 1'b0, "R8");
    send_byte(1'b0, 1'b0, "R8");
    do_stop(); drained("R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule